// File: doc/BRIEF.md
# DMA Trigger Event and Completion Interrupt Controller

This block sits in front of a DMA transfer engine. It holds one latched trigger bit for each of sixteen channels. A bit is set by a pulse on the channel's external event line, by a software write, or by a chained completion. The lowest-numbered channel that is both latched and enabled is offered to the engine through a valid/ready request. When the engine accepts the request, the latched bit for that channel is dropped.

In the other direction, the engine reports each finished transfer with a 4-bit completion code and a flag that asks for an interrupt. A flagged completion marks the pending bit that the code selects. A single CPU interrupt line is the OR of all pending bits that are also interrupt-enabled. Codes 8 to 11 can also re-trigger the channel with the same number, provided a matching chain-enable bit is set.

Software reaches seven word registers through a plain write strobe and a combinational read port.

Top module: `dma_evt_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `req_valid` is 0 and `irq` is 0.
- R2: A high bit on `evt_in`, or a 1 written to the set register (offset 0x0C), latches the matching bit of the latched-event register (offset 0x00) at the next clock edge. Writes to offset 0x00 have no effect.
- R3: A 1 written to the clear register (offset 0x08) removes that latched bit. If an external event arrives for the same bit in the same cycle, the event wins. The clear and set registers always read zero.
- R4: `req_valid` is 1 exactly when some bit is set in both the latched-event register and the enable register (offset 0x04). `req_chan` is then the lowest such bit index.
- R5: When `req_valid` and `req_ready` are both high at an edge, the latched bit of `req_chan` is cleared at that edge. If the same channel gets a new set in that cycle, the bit stays set.
- R6: A completion (`cmpl_valid` high) with `cmpl_ien`=1 sets bit `cmpl_code` of the pending register (offset 0x14) at the next edge. With `cmpl_ien`=0 the pending register does not change.
- R7: Writing 1 to a pending bit clears it. A completion that sets the same bit in the same cycle wins.
- R8: `irq` is 1 exactly when some bit is set in both the pending register and the interrupt-enable register (offset 0x18). It is driven from registers only.
- R9: A flagged completion whose code is 8 to 11, and whose bit is set in the chain-enable register (offset 0x10), latches that channel's event bit at the next edge. Only bits 8 to 11 of the chain-enable register are stored; the other bits read 0. Codes outside 8 to 11 never chain.
- R10: Register offsets are decoded from `reg_addr[4:2]`. Offset 0x1C reads zero and ignores writes. `reg_rdata` bits 31:16 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 16 | Per-channel trigger event, one-cycle pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| req_valid | output | 1 | An enabled latched event is offered |
| req_chan | output | 4 | Channel offered to the engine |
| req_ready | input | 1 | Engine accepts the offered channel |
| cmpl_valid | input | 1 | Transfer completion report |
| cmpl_code | input | 4 | Completion code of the report |
| cmpl_ien | input | 1 | Completion asks for an interrupt |
| irq | output | 1 | Combined CPU interrupt |

## Verification
Every register update lands on the first clock edge after the stimulus cycle. These include the latched events, the pending bits, the enables and the chained triggers. `req_valid`, `req_chan` and `irq` follow one edge after their cause, because they are formed from registers alone. `reg_rdata` follows `reg_addr` within the same cycle. The bench drives inputs at the falling edge and advances its reference model at the rising edge. It compares all outputs a quarter period after that rising edge, so every result is checked in the cycle it is due.

// File: rtl/dma_evt_pkg.sv
// Package: shared register index type for the DMA event/interrupt controller.
// Assumes word-aligned offsets decoded from address bits [4:2].
package dma_evt_pkg;

    typedef enum logic [2:0] {
        RI_EVT  = 3'd0,   // latched events, read only
        RI_EN   = 3'd1,   // event enable
        RI_CLR  = 3'd2,   // event clear, write only
        RI_SET  = 3'd3,   // event set, write only
        RI_CHEN = 3'd4,   // chain enable
        RI_PEND = 3'd5,   // completion pending, write 1 to clear
        RI_IEN  = 3'd6,   // interrupt enable
        RI_NONE = 3'd7    // unmapped
    } reg_idx_e;

endpackage

// File: rtl/dma_evt_latch.sv
// Module: per-channel latched trigger register.
// Sets dominate clears and acceptances in the same cycle.
// Assumes clr_vec and acc_vec are qualified by the caller.
module dma_evt_latch #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_vec,
    input  logic [NCH-1:0] clr_vec,
    input  logic [NCH-1:0] acc_vec,
    output logic [NCH-1:0] er
);

    // Latch new triggers, drop cleared or accepted ones
    always_ff @(posedge clk) begin
        if (!rst_n) er <= '0;
        else        er <= (er & ~clr_vec & ~acc_vec) | set_vec;
    end

    // R2
    set_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((er & $past(set_vec)) == $past(set_vec)));

    // R5
    accept_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|acc_vec) && ((acc_vec & set_vec) == '0)) |=> ((er & $past(acc_vec)) == '0));

endmodule

// File: rtl/dma_evt_prio.sv
// Module: fixed-priority picker, lowest index wins.
// Purely combinational; assumes nothing about the input pattern.
module dma_evt_prio #(
    parameter int NCH   = 16,
    parameter int IDX_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]   req_vec,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [NCH-1:0]   grant
);

    // Scan downwards so the lowest set bit is the last one to be written
    always_comb begin
        any = |req_vec;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_vec[i]) idx = IDX_W'(i);
        end
        grant = any ? (NCH'(1) << idx) : '0;
    end

endmodule

// File: rtl/dma_cmpl_pend.sv
// Module: completion pending bits, interrupt enable, chain enable and
// combined interrupt. Assumes a single completion per cycle.
// Chain enable stores only the bits in CHAIN_MASK.
module dma_cmpl_pend #(
    parameter int             NCH        = 16,
    parameter int             CODE_W     = $clog2(NCH),
    parameter logic [NCH-1:0] CHAIN_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmpl_valid,
    input  logic [CODE_W-1:0] cmpl_code,
    input  logic              cmpl_ien,
    input  logic [NCH-1:0]    pend_clr,
    input  logic              ien_we,
    input  logic              chen_we,
    input  logic [NCH-1:0]    wd,
    output logic [NCH-1:0]    pend,
    output logic [NCH-1:0]    ien,
    output logic [NCH-1:0]    chen,
    output logic [NCH-1:0]    chain_vec,
    output logic              irq
);

    logic [NCH-1:0] hit;

    // Decode a flagged completion into a one-hot bit
    always_comb hit = (cmpl_valid && cmpl_ien) ? (NCH'(1) << cmpl_code) : '0;

    // Pending bits: write-1-clear, completion wins
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~pend_clr) | hit;
    end

    // Software-owned enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien  <= '0;
            chen <= '0;
        end else begin
            if (ien_we)  ien  <= wd;
            if (chen_we) chen <= wd & CHAIN_MASK;
        end
    end

    assign chain_vec = hit & chen;
    assign irq       = |(pend & ien);

    // R6
    cmpl_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && cmpl_ien) |=> pend[$past(cmpl_code)]);

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pend_clr) && !cmpl_valid) |=> ((pend & $past(pend_clr)) == '0));

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && cmpl_ien && ien[cmpl_code] && !ien_we) |=> irq);

endmodule

// File: rtl/dma_evt_irq_ctrl.sv
// Module: top of the DMA event and completion interrupt controller.
// Decodes the register port, keeps the event-enable register, and wires
// the event latch, the priority picker and the completion unit.
// Assumes AW >= 5, with offsets decoded from reg_addr[4:2], and NCH <= DW.
module dma_evt_irq_ctrl #(
    parameter int  NCH      = 16,
    parameter int  AW       = 5,
    parameter int  DW       = 32,
    parameter int  CHAIN_LO = 8,
    parameter int  CHAIN_HI = 11,
    localparam int CW       = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_in,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           req_valid,
    output logic [CW-1:0]  req_chan,
    input  logic           req_ready,
    input  logic           cmpl_valid,
    input  logic [CW-1:0]  cmpl_code,
    input  logic           cmpl_ien,
    output logic           irq
);
    import dma_evt_pkg::*;

    function automatic logic [NCH-1:0] chain_mask_f();
        logic [NCH-1:0] m;
        m = '0;
        for (int i = CHAIN_LO; i <= CHAIN_HI; i++) m[i] = 1'b1;
        return m;
    endfunction
    localparam logic [NCH-1:0] CHAIN_MASK = chain_mask_f();

    reg_idx_e       widx;
    logic [NCH-1:0] wd_ch, eer, er, live, grant;
    logic [NCH-1:0] set_vec, clr_vec, acc_vec, pend_clr;
    logic [NCH-1:0] pend, ien, chen, chain_vec, rd_ch;
    logic           unused_bits;

    assign widx        = reg_idx_e'(reg_addr[4:2]);
    assign wd_ch       = reg_wdata[NCH-1:0];
    assign unused_bits = ^{reg_wdata[DW-1:NCH], reg_addr};

    // Write-strobe decode into per-channel vectors
    always_comb begin
        set_vec  = evt_in | chain_vec;
        clr_vec  = '0;
        pend_clr = '0;
        if (reg_we && widx == RI_SET)  set_vec  = set_vec | wd_ch;
        if (reg_we && widx == RI_CLR)  clr_vec  = wd_ch;
        if (reg_we && widx == RI_PEND) pend_clr = wd_ch;
    end

    // Event-enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                    eer <= '0;
        else if (reg_we && widx == RI_EN) eer <= wd_ch;
    end

    dma_evt_latch #(.NCH(NCH)) u_latch (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_vec(clr_vec), .acc_vec(acc_vec), .er(er)
    );

    assign live = er & eer;

    dma_evt_prio #(.NCH(NCH), .IDX_W(CW)) u_prio (
        .req_vec(live), .any(req_valid), .idx(req_chan), .grant(grant)
    );

    assign acc_vec = req_ready ? grant : '0;

    dma_cmpl_pend #(.NCH(NCH), .CODE_W(CW), .CHAIN_MASK(CHAIN_MASK)) u_pend (
        .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code),
        .cmpl_ien(cmpl_ien), .pend_clr(pend_clr),
        .ien_we(reg_we && widx == RI_IEN), .chen_we(reg_we && widx == RI_CHEN),
        .wd(wd_ch), .pend(pend), .ien(ien), .chen(chen),
        .chain_vec(chain_vec), .irq(irq)
    );

    // Read multiplexer; write-only and unmapped offsets read zero
    always_comb begin
        case (widx)
            RI_EVT:  rd_ch = er;
            RI_EN:   rd_ch = eer;
            RI_CHEN: rd_ch = chen;
            RI_PEND: rd_ch = pend;
            RI_IEN:  rd_ch = ien;
            default: rd_ch = '0;
        endcase
        reg_rdata = DW'(rd_ch);
    end

    // R4
    grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (($countones(grant) == 1) && ((grant & live) == grant)
                       && (((grant - NCH'(1)) & live) == '0)));

    // R4
    req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !reg_we) |=> req_valid);

    // R9
    chain_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|chain_vec) |=> ((er & $past(chain_vec)) == $past(chain_vec)));

endmodule

// File: tb/tb_dma_evt_irq_ctrl.sv
// Bench: behavioural reference model advanced at each rising edge and
// compared with all outputs a quarter period later.
module tb_dma_evt_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_in = '0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [3:0]  req_chan;
    logic        req_ready = 1'b0;
    logic        cmpl_valid = 1'b0;
    logic [3:0]  cmpl_code = '0;
    logic        cmpl_ien = 1'b0;
    logic        irq;

    always #10 clk = ~clk;   // 50 MHz

    dma_evt_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_chan(req_chan), .req_ready(req_ready),
        .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code), .cmpl_ien(cmpl_ien),
        .irq(irq)
    );

    logic [15:0] m_er, m_eer, m_ccer, m_cipr, m_cier;
    int    n_chk = 0, n_fail = 0;
    string tag = "R1";
    bit    done = 0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int lowest(input logic [15:0] v);
        int r = -1;
        for (int i = 15; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    // Reference model, then comparison a quarter period after the edge
    always @(posedge clk) begin : model
        logic [15:0] set_v, clr_v, acc_v, wd, nc;
        int lo, idx, e_lo;
        logic [15:0] e_rd;
        wd  = reg_wdata[15:0];
        idx = int'(reg_addr[4:2]);
        if (!rst_n) begin
            m_er = 0; m_eer = 0; m_ccer = 0; m_cipr = 0; m_cier = 0;
        end else begin
            lo    = lowest(m_er & m_eer);
            acc_v = (req_ready && lo >= 0) ? (16'(1) << lo) : 16'h0;
            set_v = evt_in;
            if (cmpl_valid && cmpl_ien && cmpl_code >= 8 && cmpl_code <= 11 && m_ccer[cmpl_code])
                set_v[cmpl_code] = 1'b1;
            if (reg_we && idx == 3) set_v = set_v | wd;
            clr_v = (reg_we && idx == 2) ? wd : 16'h0;
            nc = m_cipr;
            if (reg_we && idx == 5) nc = nc & ~wd;
            if (cmpl_valid && cmpl_ien) nc[cmpl_code] = 1'b1;
            m_er   = (m_er & ~clr_v & ~acc_v) | set_v;
            m_cipr = nc;
            if (reg_we && idx == 1) m_eer  = wd;
            if (reg_we && idx == 4) m_ccer = wd & 16'h0F00;
            if (reg_we && idx == 6) m_cier = wd;
        end
        #5;
        if (!done) begin
            e_lo = lowest(m_er & m_eer);
            chk("req_valid", 32'(req_valid), 32'(e_lo >= 0));
            if (e_lo >= 0) chk("req_chan", 32'(req_chan), 32'(e_lo));
            chk("irq", 32'(irq), 32'(|(m_cipr & m_cier)));
            case (reg_addr[4:2])
                3'd0: e_rd = m_er;
                3'd1: e_rd = m_eer;
                3'd4: e_rd = m_ccer;
                3'd5: e_rd = m_cipr;
                3'd6: e_rd = m_cier;
                default: e_rd = 16'h0;
            endcase
            chk("reg_rdata", reg_rdata, 32'(e_rd));
        end
    end

    // One stimulus cycle: pulses last exactly one clock
    task automatic drive(input bit we, input logic [4:0] a, input logic [31:0] d,
                         input logic [15:0] ev, input bit cv, input logic [3:0] code, input bit ie);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; evt_in = ev;
        cmpl_valid = cv; cmpl_code = code; cmpl_ien = ie;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        drive(1, a, d, 16'h0, 0, 4'h0, 0);
    endtask

    task automatic look(input logic [4:0] a);
        drive(0, a, 32'h0, 16'h0, 0, 4'h0, 0);
    endtask

    task automatic cmpl(input logic [3:0] code, input bit ie, input logic [4:0] a);
        drive(0, a, 32'h0, 16'h0, 1, code, ie);
    endtask

    initial begin
        // R1: reset state of every register and output
        tag = "R1";
        for (int a = 0; a < 32; a += 4) look(5'(a));
        rst_n = 1'b1;
        for (int a = 0; a < 32; a += 4) look(5'(a));

        // R2: external events and set register; writes to 0x00 ignored
        tag = "R2";
        drive(0, 5'h00, 0, 16'h0208, 0, 0, 0);
        look(5'h00);
        wr(5'h0C, 32'h0000_0020);
        look(5'h00);
        wr(5'h00, 32'hFFFF_FFFF);
        look(5'h00);

        // R3: clear register; event wins over clear in the same cycle
        tag = "R3";
        wr(5'h08, 32'h0000_0008);
        look(5'h00);
        drive(1, 5'h08, 32'h0000_0200, 16'h0200, 0, 0, 0);
        look(5'h00);
        look(5'h08);
        look(5'h0C);

        // R4: priority among enabled events, engine stalled
        tag = "R4";
        wr(5'h04, 32'h0000_FFFF);
        look(5'h00);
        wr(5'h0C, 32'h0000_8400);
        look(5'h04);
        wr(5'h04, 32'h0000_8000);
        look(5'h00);
        wr(5'h04, 32'h0000_0400);
        look(5'h00);
        wr(5'h04, 32'h0000_FFFF);
        look(5'h00);

        // R5: acceptance drains lowest first; new event on granted channel survives
        tag = "R5";
        req_ready = 1'b1;
        repeat (6) look(5'h00);
        req_ready = 1'b0;
        wr(5'h0C, 32'h0000_0006);
        look(5'h00);
        req_ready = 1'b1;
        drive(0, 5'h00, 0, 16'h0002, 0, 0, 0);
        look(5'h00);
        look(5'h00);
        look(5'h00);
        req_ready = 1'b0;

        // R6: flagged and unflagged completions
        tag = "R6";
        cmpl(4'd5, 1, 5'h14);
        look(5'h14);
        cmpl(4'd6, 0, 5'h14);
        look(5'h14);
        cmpl(4'd15, 1, 5'h14);
        look(5'h14);

        // R8: combined interrupt follows enable and pending
        tag = "R8";
        wr(5'h18, 32'h0000_0020);
        look(5'h18);
        wr(5'h18, 32'h0000_0000);
        look(5'h14);
        wr(5'h18, 32'h0000_8020);
        look(5'h14);

        // R7: write-1-clear; completion wins on a simultaneous clear
        tag = "R7";
        wr(5'h14, 32'h0000_0020);
        look(5'h14);
        drive(1, 5'h14, 32'h0000_8000, 0, 1, 4'd15, 1);
        look(5'h14);
        wr(5'h14, 32'h0000_FFFF);
        look(5'h14);

        // R9: chaining on codes 8..11 gated by chain enable
        tag = "R9";
        wr(5'h08, 32'h0000_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        look(5'h10);
        cmpl(4'd9, 1, 5'h00);
        look(5'h00);
        cmpl(4'd3, 1, 5'h00);
        look(5'h00);
        cmpl(4'd10, 0, 5'h00);
        look(5'h00);
        cmpl(4'd11, 1, 5'h00);
        look(5'h00);
        wr(5'h10, 32'h0000_0E00);
        cmpl(4'd8, 1, 5'h00);
        look(5'h00);
        look(5'h10);

        // R10: unmapped offset and full read sweep
        tag = "R10";
        wr(5'h1C, 32'hFFFF_FFFF);
        for (int a = 0; a < 32; a += 4) look(5'(a));
        repeat (2) look(5'h1C);

        done = 1;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule